// File: doc/BRIEF.md
# Conditioned-Adder Arithmetic Micro-Operation Unit

This block is a single-cycle register-transfer datapath. It performs every arithmetic micro-operation with one carry-lookahead adder. Two source register values arrive on the operand ports. A 3-bit operation select decides three things: whether the first adder input sees the first source or zero, what the second adder input sees, and what the carry-in is. The second adder input can be the second source, its bitwise inverse, all zeros or all ones. The adder's sum is loaded into the destination register on a rising clock edge, but only when the transfer enable is high and the operation code is a legal one.

The adder is built from 4-bit groups. Each group produces a generate and a propagate term. A second-level lookahead unit then forms the carry into every group directly from those group terms and the carry-in, so no carry ripples from bit to bit or from group to group. The carry-out and the signed-overflow flag are registered together with the result.

In a larger datapath, the operand ports come from the source registers. The enable and the operation code come from the control sequencer, and the destination register output feeds the next stage.

Top module: `cla_microop_unit`

## Requirements
- R1: With enable high and code 000 (add), the next state of {carry, result} is the unsigned sum of the first and second sources, one bit wider than the operands.
- R2: With code 001 (subtract), the result is the first source plus the inverted second source plus 1, taken modulo 2^WIDTH. The carry is 1 exactly when the first source is greater than or equal to the second as unsigned numbers.
- R3: With code 010 (increment), the result is the first source plus 1. The carry is 1 only when the first source is all ones.
- R4: With code 011 (decrement), the result is the first source plus all ones, which equals the first source minus 1. The carry is 1 whenever the first source is nonzero.
- R5: With code 100 (ones' complement), the result is the bitwise inverse of the second source and the carry is 0.
- R6: With code 101 (twos' complement), the result is the inverted second source plus 1. The carry is 1 only when the second source is zero.
- R7: On every write, the overflow flag is the XOR of the carry into the most significant bit and the carry out of it, taken from the conditioned adder inputs. This equals signed overflow of the add or the subtract.
- R8: While enable is low, the result, carry and overflow keep their values across clock edges.
- R9: Codes 110 and 111 perform no write, even when enable is high.
- R10: Reset is synchronous and active-high. It clears the result, the carry and the overflow to zero, and it takes priority over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| xfer_en | input | 1 | Control function; a write happens only when it is high |
| op_sel | input | 3 | Operation code (000 add, 001 sub, 010 inc, 011 dec, 100 ones' complement, 101 twos' complement) |
| src_a | input | WIDTH | First source register value |
| src_b | input | WIDTH | Second source register value |
| dst_q | output | WIDTH | Destination register |
| carry_q | output | 1 | Registered adder carry-out |
| ovf_q | output | 1 | Registered signed overflow |

## Verification
Every legal code is first driven with a fixed set of operand pairs:
- all zeros, which separates the codes that force a carry-in from those that do not;
- all ones plus one, which carries through every group and the second-level unit;
- the largest positive value and the most negative value, which make the overflow flag differ from the carry-out;
- equal operands, which is the subtract boundary where the carry must still be 1.

The two unused codes are driven with the same pairs, and so are cycles with enable low, to show that nothing changes. A reset is asserted together with a write to confirm that reset wins. A long run of random operands, codes and enables then checks the result, carry and overflow against a reference model after every clock.

// File: rtl/cla_microop_unit.sv
module cla_microop_unit #(
  parameter int WIDTH = 16,
  parameter int GROUP = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xfer_en,
  input  logic [2:0]       op_sel,
  input  logic [WIDTH-1:0] src_a,
  input  logic [WIDTH-1:0] src_b,
  output logic [WIDTH-1:0] dst_q,
  output logic             carry_q,
  output logic             ovf_q
);
  localparam int NGRP = WIDTH / GROUP;

  logic             zero_a, force_b, b_fill, inv_b, cin;
  logic             legal;
  logic [WIDTH-1:0] opnd_a, opnd_b, b_base;
  logic [WIDTH-1:0] g, p, c, sum;
  logic [NGRP-1:0]  gg, gp;
  logic [NGRP:0]    grp_c;

  always_comb begin
    zero_a  = 1'b0;
    force_b = 1'b0;
    b_fill  = 1'b0;
    inv_b   = 1'b0;
    cin     = 1'b0;
    legal   = 1'b1;
    case (op_sel)
      3'b000: ;
      3'b001: begin inv_b = 1'b1; cin = 1'b1; end
      3'b010: begin force_b = 1'b1; cin = 1'b1; end
      3'b011: begin force_b = 1'b1; b_fill = 1'b1; end
      3'b100: begin zero_a = 1'b1; inv_b = 1'b1; end
      3'b101: begin zero_a = 1'b1; inv_b = 1'b1; cin = 1'b1; end
      default: legal = 1'b0;
    endcase
  end

  assign opnd_a = zero_a ? '0 : src_a;
  assign b_base = force_b ? {WIDTH{b_fill}} : src_b;
  assign opnd_b = b_base ^ {WIDTH{inv_b}};

  assign g = opnd_a & opnd_b;
  assign p = opnd_a ^ opnd_b;

  always_comb begin : group_terms
    logic t;
    for (int k = 0; k < NGRP; k++) begin
      gp[k] = 1'b1;
      gg[k] = 1'b0;
      for (int m = 0; m < GROUP; m++) begin
        gp[k] = gp[k] & p[k*GROUP+m];
        t = g[k*GROUP+m];
        for (int j = m + 1; j < GROUP; j++) t = t & p[k*GROUP+j];
        gg[k] = gg[k] | t;
      end
    end
  end

  always_comb begin : second_level
    logic t;
    grp_c[0] = cin;
    for (int k = 0; k < NGRP; k++) begin
      t = cin;
      for (int j = 0; j <= k; j++) t = t & gp[j];
      grp_c[k+1] = t;
      for (int m = 0; m <= k; m++) begin
        t = gg[m];
        for (int j = m + 1; j <= k; j++) t = t & gp[j];
        grp_c[k+1] = grp_c[k+1] | t;
      end
    end
  end

  always_comb begin : bit_carries
    logic t;
    for (int k = 0; k < NGRP; k++) begin
      for (int i = 0; i < GROUP; i++) begin
        t = grp_c[k];
        for (int j = 0; j < i; j++) t = t & p[k*GROUP+j];
        c[k*GROUP+i] = t;
        for (int m = 0; m < i; m++) begin
          t = g[k*GROUP+m];
          for (int j = m + 1; j < i; j++) t = t & p[k*GROUP+j];
          c[k*GROUP+i] = c[k*GROUP+i] | t;
        end
      end
    end
  end

  assign sum = p ^ c;

  always_ff @(posedge clk) begin
    if (rst) begin
      dst_q   <= '0;
      carry_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else if (xfer_en && legal) begin
      dst_q   <= sum;
      carry_q <= grp_c[NGRP];
      ovf_q   <= grp_c[NGRP] ^ c[WIDTH-1];
    end
  end
endmodule

module cla_microop_unit_chk #(
  parameter int WIDTH = 16,
  parameter int GROUP = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             xfer_en,
  input logic [2:0]       op_sel,
  input logic [WIDTH-1:0] src_a,
  input logic [WIDTH-1:0] src_b,
  input logic [WIDTH-1:0] dst_q,
  input logic             carry_q,
  input logic             ovf_q
);
  localparam logic [WIDTH:0] ONE_X  = {{WIDTH{1'b0}}, 1'b1};
  localparam logic [WIDTH:0] FILL_X = {1'b0, {WIDTH{1'b1}}};
  localparam int GROUPS_USED = WIDTH / GROUP;

  logic [WIDTH-1:0] add_s, sub_s;
  logic             add_v, sub_v;
  assign add_s = src_a + src_b;
  assign sub_s = src_a - src_b;
  assign add_v = (src_a[WIDTH-1] == src_b[WIDTH-1]) && (add_s[WIDTH-1] != src_a[WIDTH-1]);
  assign sub_v = (src_a[WIDTH-1] != src_b[WIDTH-1]) && (sub_s[WIDTH-1] != src_a[WIDTH-1]);

  AST_ADD_RESULT: assert property (@(posedge clk) disable iff (rst)
    (xfer_en && op_sel == 3'b000) |=> ({carry_q, dst_q} == $past({1'b0, src_a} + {1'b0, src_b}))); // R1
  AST_SUB_RESULT: assert property (@(posedge clk) disable iff (rst)
    (xfer_en && op_sel == 3'b001) |=> ({carry_q, dst_q} == $past({1'b0, src_a} + {1'b0, ~src_b} + ONE_X))); // R2
  AST_INC_RESULT: assert property (@(posedge clk) disable iff (rst)
    (xfer_en && op_sel == 3'b010) |=> ({carry_q, dst_q} == $past({1'b0, src_a} + ONE_X))); // R3
  AST_DEC_RESULT: assert property (@(posedge clk) disable iff (rst)
    (xfer_en && op_sel == 3'b011) |=> ({carry_q, dst_q} == $past({1'b0, src_a} + FILL_X))); // R4
  AST_ONES_RESULT: assert property (@(posedge clk) disable iff (rst)
    (xfer_en && op_sel == 3'b100) |=> (!carry_q && dst_q == $past(~src_b))); // R5
  AST_TWOS_RESULT: assert property (@(posedge clk) disable iff (rst)
    (xfer_en && op_sel == 3'b101) |=> ({carry_q, dst_q} == $past({1'b0, ~src_b} + ONE_X))); // R6
  AST_ADD_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (xfer_en && op_sel == 3'b000) |=> (ovf_q == $past(add_v))); // R7
  AST_SUB_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (xfer_en && op_sel == 3'b001) |=> (ovf_q == $past(sub_v))); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !xfer_en |=> ($stable(dst_q) && $stable(carry_q) && $stable(ovf_q))); // R8
  AST_NO_WRITE_UNUSED: assert property (@(posedge clk) disable iff (rst)
    (xfer_en && op_sel[2:1] == 2'b11) |=> ($stable(dst_q) && $stable(carry_q) && $stable(ovf_q))); // R9
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (dst_q == '0 && !carry_q && !ovf_q)); // R10
endmodule

bind cla_microop_unit cla_microop_unit_chk #(.WIDTH(WIDTH), .GROUP(GROUP)) chk_i (
  .clk(clk), .rst(rst), .xfer_en(xfer_en), .op_sel(op_sel),
  .src_a(src_a), .src_b(src_b), .dst_q(dst_q), .carry_q(carry_q), .ovf_q(ovf_q)
);

// File: tb/cla_microop_unit_test.sv
module cla_microop_unit_test;
  localparam int W = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst, xfer_en;
  logic [2:0]   op_sel;
  logic [W-1:0] src_a, src_b;
  logic [W-1:0] dst_q;
  logic         carry_q, ovf_q;

  cla_microop_unit #(.WIDTH(W), .GROUP(4)) uut (
    .clk(clk), .rst(rst), .xfer_en(xfer_en), .op_sel(op_sel),
    .src_a(src_a), .src_b(src_b), .dst_q(dst_q), .carry_q(carry_q), .ovf_q(ovf_q)
  );

  int checks = 0;
  int failures = 0;
  bit armed = 1'b0;
  bit done = 1'b0;

  logic [W-1:0] m_r0 = '0;
  logic         m_c = 1'b0, m_v = 1'b0, m_wr = 1'b0;
  string        m_tag = "R10";

  localparam logic [W-1:0] VA [8] = '{16'h0000, 16'hFFFF, 16'h7FFF, 16'h8000,
                                       16'h1234, 16'h0000, 16'h8000, 16'h0001};
  localparam logic [W-1:0] VB [8] = '{16'h0000, 16'h0001, 16'h0001, 16'h8000,
                                       16'h1234, 16'hFFFF, 16'h0001, 16'h8000};

  function automatic logic [W+1:0] model_op(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] ea, eb;
    logic         ec;
    logic [W:0]   full;
    logic [W-1:0] low;
    ea = a; eb = b; ec = 1'b0;
    case (op)
      3'd0: begin ea = a;  eb = b;   ec = 1'b0; end
      3'd1: begin ea = a;  eb = ~b;  ec = 1'b1; end
      3'd2: begin ea = a;  eb = '0;  ec = 1'b1; end
      3'd3: begin ea = a;  eb = '1;  ec = 1'b0; end
      3'd4: begin ea = '0; eb = ~b;  ec = 1'b0; end
      default: begin ea = '0; eb = ~b; ec = 1'b1; end
    endcase
    full = {1'b0, ea} + {1'b0, eb} + {{W{1'b0}}, ec};
    low  = {1'b0, ea[W-2:0]} + {1'b0, eb[W-2:0]} + {{(W-1){1'b0}}, ec};
    return {full[W] ^ low[W-1], full};
  endfunction

  function automatic string op_tag(input logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R6";
    endcase
  endfunction

  always @(posedge clk) begin
    logic [W+1:0] r;
    armed <= 1'b1;
    if (rst) begin
      m_r0 <= '0; m_c <= 1'b0; m_v <= 1'b0; m_wr <= 1'b0; m_tag <= "R10";
    end else if (xfer_en && op_sel < 3'd6) begin
      r = model_op(op_sel, src_a, src_b);
      m_r0 <= r[W-1:0]; m_c <= r[W]; m_v <= r[W+1]; m_wr <= 1'b1;
      m_tag <= op_tag(op_sel);
    end else begin
      m_wr <= 1'b0;
      m_tag <= xfer_en ? "R9" : "R8";
    end
  end

  always @(negedge clk) begin
    if (armed && !done) begin
      checks++;
      if ({carry_q, dst_q} !== {m_c, m_r0}) begin
        failures++;
        $display("FAIL %s result/carry actual=%h/%b expected=%h/%b", m_tag, dst_q, carry_q, m_r0, m_c);
      end
      checks++;
      if (ovf_q !== m_v) begin
        failures++;
        $display("FAIL %s overflow actual=%b expected=%b", m_wr ? "R7" : m_tag, ovf_q, m_v);
      end
    end
  end

  task automatic drive(input logic en, input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    xfer_en = en; op_sel = op; src_a = a; src_b = b;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog all-requirements actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; xfer_en = 1'b0; op_sel = 3'd0; src_a = '0; src_b = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1..R7 and R9: every code against the corner operand pairs
    for (int op = 0; op < 8; op++)
      for (int v = 0; v < 8; v++)
        drive(1'b1, 3'(op), VA[v], VB[v]);
    // R8: enable low with changing operands
    for (int v = 0; v < 8; v++) drive(1'b0, 3'(v % 6), VB[v], VA[v]);
    // R10: reset wins over a write in the same cycle
    drive(1'b1, 3'd0, 16'h7FFF, 16'h7FFF);
    drive(1'b1, 3'd0, 16'hFFFF, 16'hFFFF);
    rst = 1'b1;
    drive(1'b1, 3'd2, 16'hFFFF, 16'h0000);
    rst = 1'b0;
    drive(1'b0, 3'd0, 16'h0000, 16'h0000);
    // random mix
    for (int i = 0; i < 3000; i++)
      drive(($urandom % 4) != 0, 3'($urandom % 8), W'($urandom), W'($urandom));
    drive(1'b0, 3'd0, '0, '0);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule